// File: doc/BRIEF.md
# Oversampled Serial Receiver with Per-Character Error Flags

This block receives asynchronous serial characters on a single line. It takes sixteen sample ticks per bit, and a programmable divisor sets the tick rate. Frame-control fields select the character shape: five to eight data bits, no parity or odd or even parity, and one or two stop bits. Each finished character becomes a 12-bit word. The word holds the data byte and four error flags, so the consumer can see exactly which character was damaged and in what way.

Received words are queued in a sixteen-entry first-in first-out store, or in a single holding slot when queuing is turned off. The consumer sees the oldest word directly on the output together with a ready indication. The consumer removes that word with a one-cycle pop. A timeout indication tells the consumer that data has been waiting while the line stayed quiet, so a partly filled queue can be collected without waiting for more traffic.

Top module: `uart_rx_errword`

## Requirements
- R1: Each stored word carries the received data right-aligned in bits 7:0 (unused upper data bits zero), a framing flag in bit 8, a parity flag in bit 9, an overrun flag in bit 10 and a break flag in bit 11.
- R2: frame_ctl[6:5] sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8, received least significant bit first.
- R3: frame_ctl[1] set adds a parity bit after the data. frame_ctl[2] set selects even parity and clear selects odd. A mismatch sets bit 9 of the word, and with parity off bit 9 stays clear.
- R4: frame_ctl[3] set expects two stop bits and clear expects one. If any expected stop bit is sampled low, bit 8 of the word is set.
- R5: Sample ticks occur every divisor+1 clocks, so one bit lasts 16*(divisor+1) clocks. A start bit is confirmed low at its midpoint, and every later bit is sampled at its midpoint.
- R6: A frame in which the line is low for every sampled bit through the last stop bit is stored as a break: bit 11 set, bits 9 and 8 clear, and data zero. After a break or a low stop bit, no new start is accepted until the line has been seen high.
- R7: With frame_ctl[4] set, up to 16 words are held and delivered in arrival order. With it clear, a single word is held.
- R8: A character that completes while storage is full is discarded, and the overrun flag (bit 10) is set on the most recently stored word.
- R9: While enable is low, line activity produces no words.
- R10: rx_timeout goes high when stored data is present and the receiver has been idle for 32 bit periods since the last frame. It drops when the store empties.
- R11: rx_ready is high exactly when a word is stored, and rd_word then shows the oldest word. A pop removes that word, and a pop while empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receiver clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver on when high |
| rxd | input | 1 | Serial line, idle high |
| divisor | input | DIV_W (16) | Tick divisor; bit period is 16*(divisor+1) clocks |
| frame_ctl | input | 8 | Frame format: [6:5] length, [4] queue on, [3] two stops, [2] even parity, [1] parity on |
| pop | input | 1 | Remove the word shown on rd_word |
| rd_word | output | 12 | Oldest stored word with error flags |
| rx_ready | output | 1 | At least one word stored |
| rx_timeout | output | 1 | Data waiting on a quiet line |

## Verification
Clean characters at every data length, with assorted bit patterns, show that bit ordering and right-alignment are correct. Frames with a flipped parity bit under both parity senses, and frames with a bad first or second stop bit, show which error flag each defect lands in. A line held low for a whole frame is distinguished from a plain framing error by the break flag and the suppressed parity and framing flags. Back-to-back frames into a full store, in both queued and single-slot modes, show that the overrun mark lands on the last kept word and that nothing is reordered.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP
  } rx_state_e;

  localparam int WORD_W  = 12;
  localparam int OVR_BIT = 10;

  // Data arrives LSB first into the top of an 8-bit shifter; move it down.
  function automatic logic [7:0] align_data(logic [7:0] sh, logic [1:0] wl);
    return sh >> (2'd3 - wl);
  endfunction

  function automatic logic parity_bad(logic [7:0] d, logic pbit, logic even);
    logic x;
    x = (^d) ^ pbit;
    return even ? x : ~x;
  endfunction

  function automatic logic [WORD_W-1:0] pack_word(logic [7:0] d, logic brk,
                                                  logic perr, logic ferr);
    return {brk, 1'b0, perr & ~brk, ferr & ~brk, d};
  endfunction

endpackage

// File: rtl/uart_rx_tick.sv
module uart_rx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (!en)              cnt <= '0;
    else if (cnt >= divisor)   cnt <= '0;
    else                       cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt >= divisor);
endmodule

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              rx,
  input  logic [1:0]        wlen,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              two_stop,
  output logic              push,
  output logic [WORD_W-1:0] word,
  output logic              busy
);
  rx_state_e  state;
  logic [3:0] smp;
  logic [2:0] bidx;
  logic       stop_idx, pbit, any_high, stop_low, hold_low;
  logic [7:0] shift;

  logic mid;
  assign mid  = (smp == 4'd15);
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; smp <= '0; bidx <= '0; stop_idx <= 1'b0;
      pbit <= 1'b0; any_high <= 1'b0; stop_low <= 1'b0; hold_low <= 1'b0;
      shift <= '0; push <= 1'b0; word <= '0;
    end else if (!en) begin
      state <= ST_IDLE; hold_low <= 1'b0; push <= 1'b0;
    end else begin
      push <= 1'b0;
      if (tick) begin
        unique case (state)
          ST_IDLE: begin
            if (hold_low) begin
              if (rx) hold_low <= 1'b0;
            end else if (!rx) begin
              state <= ST_START; smp <= '0;
            end
          end
          ST_START: begin
            if (smp == 4'd7) begin
              smp <= '0;
              if (!rx) begin
                state <= ST_DATA; bidx <= '0; stop_idx <= 1'b0;
                any_high <= 1'b0; stop_low <= 1'b0; pbit <= 1'b0;
              end else begin
                state <= ST_IDLE;
              end
            end else smp <= smp + 4'd1;
          end
          ST_DATA: begin
            if (mid) begin
              smp <= '0;
              shift <= {rx, shift[7:1]};
              any_high <= any_high | rx;
              if (bidx == {1'b1, wlen}) state <= par_en ? ST_PAR : ST_STOP;
              else bidx <= bidx + 3'd1;
            end else smp <= smp + 4'd1;
          end
          ST_PAR: begin
            if (mid) begin
              smp <= '0; pbit <= rx; any_high <= any_high | rx;
              state <= ST_STOP;
            end else smp <= smp + 4'd1;
          end
          ST_STOP: begin
            if (mid) begin
              smp <= '0;
              if (two_stop && !stop_idx) begin
                stop_idx <= 1'b1;
                any_high <= any_high | rx;
                if (!rx) stop_low <= 1'b1;
              end else begin
                state    <= ST_IDLE;
                push     <= 1'b1;
                hold_low <= !rx;
                word <= pack_word(align_data(shift, wlen),
                                  !(any_high | rx),
                                  par_en & parity_bad(align_data(shift, wlen), pbit, par_even),
                                  stop_low | !rx);
              end
            end else smp <= smp + 4'd1;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/uart_rx_store.sv
module uart_rx_store
  import uart_rx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] rd_word,
  output logic              not_empty,
  output logic              full,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction
  function automatic logic [PTR_W-1:0] ptr_prev(logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_W'(DEPTH-1) : p - 1'b1;
  endfunction

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cap;
  logic              do_pop, do_push, drop;

  assign cap       = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
  assign full      = (count >= cap);
  assign not_empty = (count != '0);
  assign do_pop    = pop && not_empty;
  assign do_push   = push && (!full || do_pop);
  assign drop      = push && full && !do_pop;
  assign rd_word   = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; count <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      count <= count + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push)   mem[wr_ptr] <= push_word;
    else if (drop) mem[ptr_prev(wr_ptr)][OVR_BIT] <= 1'b1;
  end
endmodule

// File: rtl/uart_rx_errword.sv
module uart_rx_errword
  import uart_rx_pkg::*;
#(
  parameter int DIV_W   = 16,
  parameter int DEPTH   = 16,
  parameter int TO_BITS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             rxd,
  input  logic [DIV_W-1:0] divisor,
  input  logic [7:0]       frame_ctl,
  input  logic             pop,
  output logic [11:0]      rd_word,
  output logic             rx_ready,
  output logic             rx_timeout
);
  localparam int CNT_W  = $clog2(DEPTH+1);
  localparam int TO_TCK = TO_BITS * 16;
  localparam int TO_W   = $clog2(TO_TCK+1);
  localparam logic [TO_W-1:0] TO_LIM = TO_W'(TO_TCK);

  logic rx_meta, rx_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rx_meta <= 1'b1; rx_sync <= 1'b1; end
    else        begin rx_meta <= rxd;  rx_sync <= rx_meta; end
  end

  logic unused_fc;
  assign unused_fc = ^{frame_ctl[7], frame_ctl[0]};

  // Named internal events, observed by the bound checker.
  logic              tick, frm_push, frm_busy, st_full;
  logic [WORD_W-1:0] frm_word;
  logic [CNT_W-1:0]  st_count;

  uart_rx_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(enable), .divisor(divisor), .tick(tick));

  uart_rx_frame u_frame (
    .clk(clk), .rst_n(rst_n), .en(enable), .tick(tick), .rx(rx_sync),
    .wlen(frame_ctl[6:5]), .par_en(frame_ctl[1]), .par_even(frame_ctl[2]),
    .two_stop(frame_ctl[3]), .push(frm_push), .word(frm_word), .busy(frm_busy));

  uart_rx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .fifo_en(frame_ctl[4]), .push(frm_push),
    .push_word(frm_word), .pop(pop), .rd_word(rd_word), .not_empty(rx_ready),
    .full(st_full), .count(st_count));

  logic [TO_W-1:0] to_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        to_cnt <= '0;
    else if (!rx_ready || frm_busy)    to_cnt <= '0;
    else if (tick && to_cnt != TO_LIM) to_cnt <= to_cnt + 1'b1;
  end
  assign rx_timeout = rx_ready && (to_cnt == TO_LIM);
endmodule

// File: rtl/uart_rx_errword_chk.sv
module uart_rx_errword_chk #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       enable,
  input logic                       pop,
  input logic                       rx_ready,
  input logic                       rx_timeout,
  input logic                       push,
  input logic [11:0]                push_word,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       full
);
  localparam int CNT_W = $clog2(DEPTH+1);

  a_r9_no_word_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> !push);

  a_r6_break_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_word[11]) |-> (push_word[9:8] == 2'b00 && push_word[7:0] == 8'h00));

  a_r10_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_timeout |-> rx_ready);

  a_r8_drop_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !(pop && rx_ready)) |=> (count == $past(count)));

  a_r11_pop_takes_one: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rx_ready && !push) |=> (count == CNT_W'($past(count) - 1'b1)));

  a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
endmodule

bind uart_rx_errword uart_rx_errword_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .pop(pop), .rx_ready(rx_ready),
  .rx_timeout(rx_timeout), .push(frm_push), .push_word(frm_word),
  .count(st_count), .full(st_full));

// File: tb/uart_rx_errword_bench.sv
`timescale 1ns/1ps
module uart_rx_errword_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        rxd = 1'b1;
  logic [15:0] divisor = 16'd1;
  logic [7:0]  fc = 8'h70;
  logic        pop_mon = 1'b0, pop_tb = 1'b0;
  logic [11:0] rd_word;
  logic        rx_ready, rx_timeout;

  int n_chk = 0, n_fail = 0;
  bit mon_on = 1'b0, done = 1'b0;
  string cur_req = "R1";
  logic [11:0] q[$];

  always #10 clk = ~clk;

  uart_rx_errword u_uart_rx_errword (
    .clk(clk), .rst_n(rst_n), .enable(enable), .rxd(rxd), .divisor(divisor),
    .frame_ctl(fc), .pop(pop_mon | pop_tb), .rd_word(rd_word),
    .rx_ready(rx_ready), .rx_timeout(rx_timeout));

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int bit_clk();
    return 16 * (int'(divisor) + 1);
  endfunction

  task automatic line(logic v, int nbits);
    rxd = v;
    repeat (nbits * bit_clk()) @(negedge clk);
  endtask

  // Driver: sends one frame and records the word it should produce.
  task automatic send_frame(logic [7:0] d, bit bad_par, logic [1:0] bad_stop,
                            bit expect_it, bit drop);
    int n = 5 + int'(fc[6:5]);
    int nstop = fc[3] ? 2 : 1;
    logic [7:0] md = d & 8'((1 << n) - 1);
    int ones = 0;
    logic p;
    logic ferr = 1'b0;
    for (int i = 0; i < n; i++) ones += int'(md[i]);
    p = fc[2] ? logic'(ones % 2) : logic'(1 - ones % 2);
    for (int s = 0; s < nstop; s++) ferr |= bad_stop[s];
    if (expect_it && !drop) q.push_back({2'b00, fc[1] & bad_par, ferr, md});
    line(1'b0, 1);
    for (int i = 0; i < n; i++) line(md[i], 1);
    if (fc[1]) line(p ^ bad_par, 1);
    for (int s = 0; s < nstop; s++) line(~bad_stop[s], 1);
    rxd = 1'b1;
    if (drop) q[q.size()-1] = q[q.size()-1] | 12'h400;
    line(1'b1, 1);
  endtask

  task automatic send_break();
    int len = 1 + 5 + int'(fc[6:5]) + (fc[1] ? 1 : 0) + (fc[3] ? 2 : 1);
    q.push_back(12'h800);
    line(1'b0, len + 2);
    line(1'b1, 2);
  endtask

  task automatic drain(string req);
    int k = 0;
    mon_on = 1'b1;
    while ((q.size() != 0 || rx_ready) && k < 20000) begin
      @(negedge clk); k++;
    end
    chk(req, "words still expected", q.size(), 0);
  endtask

  // Monitor: compares the word on the output against the scoreboard.
  initial forever begin
    @(negedge clk);
    if (mon_on && rx_ready) begin
      if (q.size() == 0) chk(cur_req, "unexpected word", {20'h0, rd_word}, 32'hFFFF_FFFF);
      else chk(cur_req, "word", {20'h0, rd_word}, {20'h0, q.pop_front()});
      pop_mon = 1'b1;
      @(negedge clk);
      pop_mon = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R11", "ready after reset", rx_ready, 0);
    chk("R10", "timeout after reset", rx_timeout, 0);
    rst_n = 1'b1; enable = 1'b1;
    repeat (40) @(negedge clk);
    mon_on = 1'b1;

    // R1 / R5: 8N1 patterns
    cur_req = "R1";
    send_frame(8'hA5, 0, 2'b00, 1, 0);
    send_frame(8'h3C, 0, 2'b00, 1, 0);
    send_frame(8'hFF, 0, 2'b00, 1, 0);
    send_frame(8'h00, 0, 2'b00, 1, 0);
    drain("R1");

    // R2: shorter lengths, upper bits must read zero
    cur_req = "R2";
    for (int wl = 0; wl < 3; wl++) begin
      fc = 8'h10 | 8'(wl << 5);
      send_frame(8'hFF, 0, 2'b00, 1, 0);
      send_frame(8'hB6, 0, 2'b00, 1, 0);
    end
    drain("R2");

    // R3: even and odd parity, good and bad
    cur_req = "R3";
    fc = 8'h76;
    send_frame(8'h37, 0, 2'b00, 1, 0);
    send_frame(8'h37, 1, 2'b00, 1, 0);
    fc = 8'h72;
    send_frame(8'h37, 0, 2'b00, 1, 0);
    send_frame(8'h81, 1, 2'b00, 1, 0);
    fc = 8'h56;
    send_frame(8'h15, 1, 2'b00, 1, 0);
    drain("R3");

    // R4: stop bit handling
    cur_req = "R4";
    fc = 8'h70;
    send_frame(8'h5E, 0, 2'b01, 1, 0);
    fc = 8'h78;
    send_frame(8'h5E, 0, 2'b00, 1, 0);
    send_frame(8'hC3, 0, 2'b10, 1, 0);
    send_frame(8'h24, 0, 2'b01, 1, 0);
    drain("R4");

    // R6: break, with odd parity and without parity
    cur_req = "R6";
    fc = 8'h72;
    send_break();
    fc = 8'h70;
    send_break();
    send_frame(8'h6D, 0, 2'b00, 1, 0);
    drain("R6");

    // R5: slower divisor
    cur_req = "R5";
    divisor = 16'd4;
    send_frame(8'h9A, 0, 2'b00, 1, 0);
    send_frame(8'h01, 0, 2'b00, 1, 0);
    drain("R5");
    divisor = 16'd1;
    line(1'b1, 2);

    // R7 / R8: fill queue, one extra character overruns
    cur_req = "R8";
    mon_on = 1'b0;
    for (int i = 0; i < 17; i++) send_frame(8'(i + 8'h40), 0, 2'b00, 1, i == 16);
    chk("R7", "ready with full queue", rx_ready, 1);
    drain("R7");

    // R11: pop while empty is ignored
    cur_req = "R11";
    @(negedge clk); pop_tb = 1'b1; @(negedge clk); pop_tb = 1'b0;
    chk("R11", "ready after empty pop", rx_ready, 0);
    send_frame(8'h5A, 0, 2'b00, 1, 0);
    drain("R11");

    // R7 / R8: single holding slot
    cur_req = "R8";
    mon_on = 1'b0;
    fc = 8'h60;
    send_frame(8'h11, 0, 2'b00, 1, 0);
    send_frame(8'h22, 0, 2'b00, 1, 1);
    drain("R8");

    // R9: disabled receiver ignores the line
    cur_req = "R9";
    fc = 8'h70;
    @(negedge clk); enable = 1'b0;
    send_frame(8'h77, 0, 2'b00, 0, 0);
    chk("R9", "ready while disabled", rx_ready, 0);
    enable = 1'b1;
    line(1'b1, 2);
    send_frame(8'h78, 0, 2'b00, 1, 0);
    drain("R9");

    // R10: timeout after 32 idle bit periods
    cur_req = "R10";
    mon_on = 1'b0;
    send_frame(8'h42, 0, 2'b00, 1, 0);
    line(1'b1, 29);
    chk("R10", "timeout before 32 bits", rx_timeout, 0);
    line(1'b1, 4);
    chk("R10", "timeout after 32 bits", rx_timeout, 1);
    drain("R10");
    chk("R10", "timeout after drain", rx_timeout, 0);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule